// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counting Timer

This block holds five independent down-counting timer channels behind a simple 32-bit register port. A single write strobe, an address and write data come in, and read data is returned combinationally from the address. Each channel has a control/status word, a 24-bit start value and a read-only live count. Once enabled, a channel steps its count down by one every (divider + 1) clock cycles. It runs either once or repeatedly, and it can be halted and resumed without losing its place.

When a channel reaches its end it sets its bit in a shared event-flag register. That flag drives the channel's interrupt line when the channel's interrupt-enable bit is set. Software clears a flag by writing a 1 to its bit. A second shared word at offset 0x1C is a placeholder for an unrelated watchdog function and always reads 0x0000_0400.

Top module: `mtmr_top`

## Requirements
- R1: After reset every control word reads 0x0000_0005 (divider 5, all other bits 0). Every start value, live count and the event-flag register (0x18) read 0, the word at 0x1C reads 0x0000_0400 and all interrupt lines are low.
- R2: Control bits are: run-enable bit 30, interrupt-enable bit 29, repeat-mode bit 27 (1 = periodic), clear strobe bit 26 (reads 0), armed status bit 25 (read-only) and divider bits 7:0. Setting run-enable on an idle channel with a nonzero start value makes bits 30 and 25 read 1 and the live count read the start value on the next cycle.
- R3: The event flag of a started channel is set at exactly start×(divider+1) clock edges after the edge that took the enabling write, and not one edge earlier.
- R4: In one-shot mode (bit 27 = 0), expiry clears bits 30 and 25 and reloads the live count with the start value. The channel then raises no further events.
- R5: In periodic mode the channel reloads and keeps running after each expiry, and it sets its flag once every start×(divider+1) cycles.
- R6: A channel's interrupt line is high exactly while its flag is set and its interrupt-enable bit is 1.
- R7: Writing the event-flag register clears each flag whose write-data bit is 1 and leaves flags whose bit is 0 untouched. A flag set by an expiry on the same edge as a clearing write stays set.
- R8: A control write with the clear strobe set forces run-enable and armed to 0 and the live count and divider phase to 0, whatever bit 30 holds. It sets no flag.
- R9: Clearing run-enable on a running channel freezes both the live count and the divider phase. Setting it again resumes from the frozen state, so expiry is delayed by exactly the number of halted edges.
- R10: A control write that keeps run-enable at 1 but changes the divider leaves the live count unchanged. Later steps use the new divider.
- R11: Enabling an idle channel whose start value is 0 sets its flag on that same write edge, leaves bits 30 and 25 at 0, and keeps the interrupt line low when bit 29 is 0.
- R12: Channel n (0..4) has its control word at (n/2)×0x20 + (n%2)×4, its start value 0x08 above that and its live count 0x10 above that. Only the low 24 bits of a start value are kept, and a write reaches only its own register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the counting reference |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 5 | Per-channel interrupt lines |

## Verification
Every register update, including the zero-start flag and the live count after an enable, is visible one edge after the writing edge. Reads are combinational, so the bench drives writes and sets addresses on the falling edge and samples shortly afterwards. An expiry lands exactly start×(divider+1) edges after the enabling edge, and the bench counts falling edges from that write to probe the edge just before and the edge of expiry. It does the same after halts, divider changes and flag-clearing writes, so that a clearing write can be placed on the very edge of a periodic expiry.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int DATA_W   = 32;
  localparam int B_RUN    = 30;
  localparam int B_IEN    = 29;
  localparam int B_REP    = 27;
  localparam int B_CLR    = 26;
  localparam int B_ARM    = 25;
  localparam int FLAG_OFS = 'h18;
  localparam int WDG_OFS  = 'h1C;
  localparam int START_DELTA = 'h08;
  localparam int LIVE_DELTA  = 'h10;
  localparam logic [DATA_W-1:0] WDG_VALUE = 32'h0000_0400;

  function automatic int ctl_offset(input int n);
    return (n / 2) * 'h20 + (n % 2) * 4;
  endfunction
endpackage

// File: rtl/mtmr_decode.sv
module mtmr_decode
  import mtmr_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    ctl_sel,
  output logic [NCH-1:0]    start_sel,
  output logic [NCH-1:0]    live_sel,
  output logic              flag_sel,
  output logic              wdg_sel
);
  for (genvar n = 0; n < NCH; n++) begin : g_sel
    assign ctl_sel[n]   = (addr == ADDR_W'(ctl_offset(n)));
    assign start_sel[n] = (addr == ADDR_W'(ctl_offset(n) + START_DELTA));
    assign live_sel[n]  = (addr == ADDR_W'(ctl_offset(n) + LIVE_DELTA));
  end
  assign flag_sel = (addr == ADDR_W'(FLAG_OFS));
  assign wdg_sel  = (addr == ADDR_W'(WDG_OFS));

  // R12
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_sel, start_sel, live_sel, flag_sel, wdg_sel}));
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel
  import mtmr_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PS_W   = 8,
  parameter int PS_RST = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              start_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_rd,
  output logic [CNT_W-1:0]  start_rd,
  output logic [CNT_W-1:0]  live_rd,
  output logic              ien_o,
  output logic              evt_o
);
  logic run_q, run_d, ien_q, ien_d, rep_q, rep_d, arm_q, arm_d;
  logic [PS_W-1:0]  div_q, div_d, ph_q, ph_d;
  logic [CNT_W-1:0] st_q, st_d, cnt_q, cnt_d;
  logic evt, step;

  assign step = run_q && arm_q && (ph_q >= div_q);

  always_comb begin
    run_d = run_q; ien_d = ien_q; rep_d = rep_q; arm_d = arm_q;
    div_d = div_q; ph_d = ph_q; st_d = st_q; cnt_d = cnt_q;
    evt   = 1'b0;
    if (run_q && arm_q) begin
      if (step) begin
        ph_d = '0;
        if (cnt_q <= CNT_W'(1)) begin
          evt   = 1'b1;
          cnt_d = st_q;
          if (!rep_q) begin
            run_d = 1'b0;
            arm_d = 1'b0;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end else begin
        ph_d = ph_q + PS_W'(1);
      end
    end
    if (start_we) st_d = wdata[CNT_W-1:0];
    if (ctl_we) begin
      ien_d = wdata[B_IEN];
      rep_d = wdata[B_REP];
      div_d = wdata[PS_W-1:0];
      if (wdata[B_CLR]) begin
        run_d = 1'b0; arm_d = 1'b0; cnt_d = '0; ph_d = '0; evt = 1'b0;
      end else if (!wdata[B_RUN]) begin
        run_d = 1'b0;
      end else if (!run_q) begin
        if (arm_q) begin
          run_d = 1'b1;
        end else if (st_q == '0) begin
          evt = 1'b1;
        end else begin
          run_d = 1'b1; arm_d = 1'b1; cnt_d = st_q; ph_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; ien_q <= 1'b0; rep_q <= 1'b0; arm_q <= 1'b0;
      div_q <= PS_W'(PS_RST); ph_q <= '0; st_q <= '0; cnt_q <= '0;
    end else begin
      run_q <= run_d; ien_q <= ien_d; rep_q <= rep_d; arm_q <= arm_d;
      div_q <= div_d; ph_q <= ph_d; st_q <= st_d; cnt_q <= cnt_d;
    end
  end

  always_comb begin
    ctl_rd          = '0;
    ctl_rd[B_RUN]   = run_q;
    ctl_rd[B_IEN]   = ien_q;
    ctl_rd[B_REP]   = rep_q;
    ctl_rd[B_ARM]   = arm_q;
    ctl_rd[PS_W-1:0] = div_q;
  end
  assign start_rd = st_q;
  assign live_rd  = cnt_q;
  assign ien_o    = ien_q;
  assign evt_o    = evt;

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctl_we) |=> ($stable(cnt_q) && $stable(ph_q)));
  // R8
  clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && wdata[B_CLR]) |=> (!run_q && !arm_q && cnt_q == '0 && !$past(evt_o)));
  // R4
  oneshot_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && run_q && !rep_q && !ctl_we) |=> (!run_q && !arm_q && cnt_q == $past(st_q)));
  // R10
  div_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && run_q && wdata[B_RUN] && !wdata[B_CLR] && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/mtmr_flags.sv
module mtmr_flags #(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  input  logic [NCH-1:0] ien_i,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] flag_q, flag_d, clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_comb begin
    flag_d = (flag_q & ~clr_eff) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ien_i;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flag_q & $past(clr_mask & ~set_i)) == '0));
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
  import mtmr_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24,
  parameter int PS_W   = 8,
  parameter int PS_RST = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq
);
  logic [NCH-1:0] ctl_sel, start_sel, live_sel, evt, ien, flags;
  logic           flag_sel, wdg_sel;
  logic [DATA_W-1:0] ctl_rd [NCH];
  logic [CNT_W-1:0]  st_rd  [NCH];
  logic [CNT_W-1:0]  cnt_rd [NCH];

  mtmr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .ctl_sel(ctl_sel), .start_sel(start_sel), .live_sel(live_sel),
    .flag_sel(flag_sel), .wdg_sel(wdg_sel)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    mtmr_channel #(.CNT_W(CNT_W), .PS_W(PS_W), .PS_RST(PS_RST)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(bus_we && ctl_sel[n]), .start_we(bus_we && start_sel[n]),
      .wdata(bus_wdata), .ctl_rd(ctl_rd[n]), .start_rd(st_rd[n]),
      .live_rd(cnt_rd[n]), .ien_o(ien[n]), .evt_o(evt[n])
    );
  end

  mtmr_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt),
    .clr_we(bus_we && flag_sel), .clr_mask(bus_wdata[NCH-1:0]),
    .ien_i(ien), .flag_o(flags), .irq_o(irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      if (ctl_sel[n])   bus_rdata = bus_rdata | ctl_rd[n];
      if (start_sel[n]) bus_rdata = bus_rdata | DATA_W'(st_rd[n]);
      if (live_sel[n])  bus_rdata = bus_rdata | DATA_W'(cnt_rd[n]);
    end
    if (flag_sel) bus_rdata = bus_rdata | DATA_W'(flags);
    if (wdg_sel)  bus_rdata = bus_rdata | WDG_VALUE;
  end
endmodule

// File: tb/mtmr_top_bench.sv
`timescale 1ns/10ps
module mtmr_top_bench;
  localparam int NCH = 5;
  localparam logic [31:0] RUN = 32'h4000_0000, IEN = 32'h2000_0000,
                          REP = 32'h0800_0000, CLR = 32'h0400_0000,
                          ARM = 32'h0200_0000;
  localparam logic [7:0] FLAGS = 8'h18, WDG = 8'h1C;

  logic clk = 1'b0;
  logic rst_n, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NCH-1:0] irq;

  always #2 clk = ~clk;

  mtmr_top u_mtmr_top (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    logic        is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  event  sample_ev;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  function automatic logic [7:0] ctl_a(int n);
    return 8'((n / 2) * 32 + (n % 2) * 4);
  endfunction
  function automatic logic [7:0] start_a(int n);
    return ctl_a(n) + 8'h08;
  endfunction
  function automatic logic [7:0] live_a(int n);
    return ctl_a(n) + 8'h10;
  endfunction

  // monitor: pops the expected item and compares it against the design output
  initial begin
    forever begin
      @(sample_ev);
      begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? 32'(irq) : bus_rdata;
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    item_t it;
    bus_addr = a;
    #0.1;
    it.is_irq = 1'b0; it.exp = e; it.req = r;
    sb_q.push_back(it);
    -> sample_ev;
    #0.1;
  endtask

  task automatic chk_irq(input logic [31:0] e, input string r);
    item_t it;
    #0.1;
    it.is_irq = 1'b1; it.exp = e; it.req = r;
    sb_q.push_back(it);
    -> sample_ev;
    #0.1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    chk_rd(ctl_a(0), 32'h5, "R1 ctl0");
    chk_rd(ctl_a(4), 32'h5, "R1 ctl4");
    chk_rd(start_a(0), 32'h0, "R1 start0");
    chk_rd(live_a(3), 32'h0, "R1 live3");
    chk_rd(FLAGS, 32'h0, "R1 flags");
    wait_cyc(1);
    chk_rd(WDG, 32'h400, "R1 wdg");
    chk_irq(32'h0, "R1 irq");

    // R8 clear strobe beats run-enable
    wr(ctl_a(1), RUN | CLR | 32'h5);
    chk_rd(ctl_a(1), 32'h5, "R8 ctl1");
    chk_rd(live_a(1), 32'h0, "R8 live1");
    chk_rd(FLAGS, 32'h0, "R8 flags");

    // R11 zero start value flags at once
    wr(ctl_a(2), RUN | 32'h5);
    chk_rd(FLAGS, 32'h4, "R11 flag2");
    chk_rd(ctl_a(2), 32'h5, "R11 ctl2");
    chk_irq(32'h0, "R11 irq low");
    wr(FLAGS, 32'h0);
    chk_rd(FLAGS, 32'h4, "R7 zero write");
    wr(FLAGS, 32'h4);
    chk_rd(FLAGS, 32'h0, "R7 w1c");

    // R2 R3 R4 one-shot, start 4, divider 2 -> 12 edges
    wr(start_a(0), 32'd4);
    wr(ctl_a(0), RUN | 32'h2);
    chk_rd(ctl_a(0), RUN | ARM | 32'h2, "R2 ctl0");
    chk_rd(live_a(0), 32'd4, "R2 live0");
    wait_cyc(11);
    chk_rd(FLAGS, 32'h0, "R3 not early");
    wait_cyc(1);
    chk_rd(FLAGS, 32'h1, "R3 on time");
    chk_rd(ctl_a(0), 32'h2, "R4 ctl0");
    chk_rd(live_a(0), 32'd4, "R4 reload");
    chk_irq(32'h0, "R6 gated");
    wr(FLAGS, 32'h1);
    wait_cyc(30);
    chk_rd(FLAGS, 32'h0, "R4 no repeat");

    // R5 R6 periodic, start 3, divider 1 -> 6 edges
    wr(start_a(3), 32'd3);
    wr(ctl_a(3), RUN | IEN | REP | 32'h1);
    wait_cyc(5);
    chk_irq(32'h0, "R5 not early");
    wait_cyc(1);
    chk_irq(32'h8, "R5 irq");
    chk_rd(FLAGS, 32'h8, "R5 flag");
    for (int k = 0; k < 2; k++) begin
      wr(FLAGS, 32'h8);
      chk_irq(32'h0, "R6 cleared");
      chk_rd(FLAGS, 32'h0, "R7 cleared");
      wait_cyc(4);
      chk_rd(FLAGS, 32'h0, "R5 mid period");
      wait_cyc(1);
      chk_rd(FLAGS, 32'h8, "R5 next period");
      chk_irq(32'h8, "R6 irq period");
    end

    // R7 clear on the expiry edge loses to the set
    wr(FLAGS, 32'h8);
    wait_cyc(4);
    wr(FLAGS, 32'h8);
    chk_rd(FLAGS, 32'h8, "R7 set wins");
    wr(ctl_a(3), CLR | 32'h1);
    wr(FLAGS, 32'h8);
    chk_rd(FLAGS, 32'h0, "R7 cleared after stop");
    chk_irq(32'h0, "R6 irq low");

    // R9 halt keeps count and divider phase
    wr(ctl_a(0), CLR | 32'h1);
    wr(ctl_a(0), RUN | 32'h1);
    wait_cyc(2);
    wr(ctl_a(0), 32'h1);
    chk_rd(live_a(0), 32'd3, "R9 halted count");
    chk_rd(ctl_a(0), ARM | 32'h1, "R9 halted ctl");
    wait_cyc(20);
    chk_rd(live_a(0), 32'd3, "R9 count held");
    chk_rd(FLAGS, 32'h0, "R9 no flag");
    wr(ctl_a(0), RUN | 32'h1);
    wait_cyc(4);
    chk_rd(FLAGS, 32'h0, "R9 not early");
    wait_cyc(1);
    chk_rd(FLAGS, 32'h1, "R9 resume expiry");

    // R10 divider change keeps count
    wr(FLAGS, 32'h1);
    wr(ctl_a(0), CLR | 32'h3);
    wr(start_a(0), 32'd8);
    wr(ctl_a(0), RUN | 32'h3);
    wait_cyc(8);
    chk_rd(live_a(0), 32'd6, "R10 before change");
    wr(ctl_a(0), RUN | 32'h0);
    chk_rd(live_a(0), 32'd6, "R10 count kept");
    chk_rd(ctl_a(0), RUN | ARM, "R10 ctl");
    wait_cyc(5);
    chk_rd(live_a(0), 32'd1, "R10 new divider");
    chk_rd(FLAGS, 32'h0, "R10 not early");
    wait_cyc(1);
    chk_rd(FLAGS, 32'h1, "R10 expiry");

    // R12 map and isolation
    wr(start_a(4), 32'h00AB_CDEF);
    chk_rd(start_a(4), 32'h00AB_CDEF, "R12 start4");
    chk_rd(live_a(4), 32'h0, "R12 live4 idle");
    chk_rd(start_a(0), 32'd8, "R12 start0 kept");
    wr(start_a(4), 32'hFF12_3456);
    chk_rd(start_a(4), 32'h0012_3456, "R12 24-bit");
    chk_rd(ctl_a(2), 32'h5, "R12 ctl2 kept");

    done = 1'b1;
    wait_cyc(1);
    report();
  end
endmodule